// File: doc/BRIEF.md
# STN Panel Pixel Formatter

This block turns a packed frame buffer into the data stream for a monochrome or colour STN LCD panel. It walks the visible panel window one lane at a time. For each lane it computes which pixel of a larger logical screen appears there, and it reads the buffer word that holds that pixel. It then gathers the lanes into a 4-bit or 8-bit group and presents each group with a one-cycle shift clock. A line pulse marks the end of every panel line, and a frame pulse marks the end of the first line of every frame.

Source pixels can be 1, 2 or 4 bits wide. A pan offset in both axes picks the origin of the window inside the logical screen. Horizontal dot doubling and vertical line doubling stretch a small source image onto a larger panel. In dual-scan mode every group carries the upper half-screen on its high lanes and the lower half-screen on its low lanes. Grey-shade modulation is outside this block, so each lane carries the most significant bit of its pixel.

The buffer port has a fixed one-cycle read latency. The configuration inputs must be held stable while `enable` is high. Lowering `enable` restarts the scan at the top of the frame.

Top module: `lcdfmt_top`

## Requirements
- R1: After reset, and from the first clock edge on which `enable` is sampled low, `lcd_data`, `lcd_shclk`, `lcd_line` and `lcd_frame` are all zero.
- R2: `bpp_sel` selects the pixel width: 0 gives 1 bit, 1 gives 2 bits, and 2 or 3 give 4 bits. A WORD_W-bit word holds `ppw` = WORD_W/bpp pixels. Pixel i of a word occupies the bits whose top bit is bit WORD_W-1-i*bpp, and that top bit is the value placed on the lane. Logical pixel (sx, sy) is read from word address sy*`pitch` + sx/ppw, and the address wraps to AW bits.
- R3: With `bus8`=1 each group has 8 lanes on `lcd_data[7:0]`. With `bus8`=0 it has 4 lanes on `lcd_data[3:0]`, and `lcd_data[7:4]` is zero. The first lane of a group goes out on the highest lane bit.
- R4: With `dual`=1 the first half of the lanes in a group come from panel row y and the second half from row y+`v_active`/2, and one frame has `v_active`/2 lines. With `dual`=0 all lanes come from row y, and one frame has `v_active` lines.
- R5: With `dot_dbl`=1, panel column x shows logical column x/2, so each source pixel appears on two neighbouring lanes.
- R6: With `line_dbl`=1, panel row r shows logical row r/2, so each source line appears on two panel rows.
- R7: Panel position (x, r) shows logical pixel (`pan_x`+x', `pan_y`+r'), where x' and r' are the coordinates after doubling.
- R8: Each line carries `h_active`/lanes-per-row shift clocks. The line pulse comes exactly one cycle after the last shift clock of the line.
- R9: `lcd_frame` is high together with the line pulse of row 0 of each frame, and it is low on every other line pulse.
- R10: `lcd_shclk` is a one-cycle pulse that never coincides with `lcd_line`. While enabled, consecutive shift clocks are exactly 4 (`bus8`=0) or 8 (`bus8`=1) cycles apart, including across line and frame boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the scan; low restarts it at frame start |
| bpp_sel | input | 2 | Pixel width select (0:1, 1:2, 2/3:4 bits) |
| bus8 | input | 1 | 1: 8-lane panel bus, 0: 4-lane |
| dual | input | 1 | 1: dual-scan order |
| dot_dbl | input | 1 | Horizontal pixel doubling |
| line_dbl | input | 1 | Vertical line doubling |
| h_active | input | XW | Panel pixels per row (multiple of 8) |
| v_active | input | YW | Panel rows (even) |
| pitch | input | XW | Logical line length in words |
| pan_x | input | XW | Window origin column in the logical screen |
| pan_y | input | YW | Window origin row in the logical screen |
| fb_addr | output | AW | Frame buffer word address |
| fb_data | input | WORD_W | Buffer word, one cycle after its address |
| lcd_data | output | 8 | Panel lane group |
| lcd_shclk | output | 1 | Shift clock pulse per group |
| lcd_line | output | 1 | Line pulse |
| lcd_frame | output | 1 | Frame pulse |

## Verification
The bench recomputes every group from a pure function that models the buffer contents. A wrong bit order inside a word, or the wrong slice chosen for a given pixel width, then shows up as scrambled lanes. Odd pan offsets combined with dot doubling catch a design that doubles after panning instead of before. Dual-scan runs catch a design that takes the lower half from the wrong row or keeps the full line count, which would shift the frame pulse. The bench also times line pulses against the last shift clock and checks the group count per line, which exposes off-by-one group limits and pulses one cycle late. After each run it drops `enable` and checks that the outputs go quiet.

// File: rtl/lcdfmt_pkg.sv
package lcdfmt_pkg;

   // pixel width selection codes
   typedef enum logic [1:0] {
      BPP_1 = 2'd0,
      BPP_2 = 2'd1,
      BPP_4 = 2'd2,
      BPP_4X = 2'd3
   } bpp_e;

   // number of pixel width variants built by the fetch stage
   localparam int NBPP = 3;

   // per-lane tag carried through the read pipeline
   typedef struct packed {
      logic last_lane;
      logic end_line;
      logic first_line;
   } lane_tag_t;

   // log2 of lanes per panel row for one group
   function automatic logic [1:0] lanes_log2(input logic bus8, input logic dual);
      case ({bus8, dual})
         2'b00: return 2'd2;
         2'b01: return 2'd1;
         2'b10: return 2'd3;
         default: return 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/lcdfmt_scan.sv
module lcdfmt_scan
   import lcdfmt_pkg::*;
#(
   parameter int XW = 11,
   parameter int YW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          bus8,
   input  logic          dual,
   input  logic          dot_dbl,
   input  logic          line_dbl,
   input  logic [XW-1:0] h_active,
   input  logic [YW-1:0] v_active,
   input  logic [XW-1:0] pan_x,
   input  logic [YW-1:0] pan_y,
   output logic [XW-1:0] src_x,
   output logic [YW-1:0] src_y,
   output logic          step_vld,
   output lane_tag_t     step_tag
);

   logic [2:0]    lane;
   logic [XW-1:0] grp;
   logic [YW-1:0] row;
   logic [1:0]    lh_log2;
   logic [2:0]    lane_max;
   logic [XW-1:0] grp_last;
   logic [YW-1:0] row_last;
   logic [3:0]    lh_cnt;
   logic          lower;
   logic [2:0]    lane_in_row;
   logic [XW-1:0] pan_col;
   logic [YW-1:0] pan_row;
   logic          at_lane_end;
   logic          at_grp_end;
   logic          at_row_end;

   always_comb begin
      lh_log2     = lanes_log2(bus8, dual);
      lane_max    = bus8 ? 3'd7 : 3'd3;
      lh_cnt      = 4'd1 << lh_log2;
      grp_last    = (h_active >> lh_log2) - XW'(1);
      row_last    = (dual ? (v_active >> 1) : v_active) - YW'(1);
      lower       = dual && ({1'b0, lane} >= lh_cnt);
      lane_in_row = lane & 3'(lh_cnt - 4'd1);
      pan_col     = (grp << lh_log2) | XW'(lane_in_row);
      pan_row     = row + (lower ? (v_active >> 1) : YW'(0));
      src_x       = pan_x + (dot_dbl ? (pan_col >> 1) : pan_col);
      src_y       = pan_y + (line_dbl ? (pan_row >> 1) : pan_row);
      at_lane_end = (lane == lane_max);
      at_grp_end  = at_lane_end && (grp == grp_last);
      at_row_end  = at_grp_end && (row == row_last);
      step_vld    = enable;
      step_tag.last_lane  = at_lane_end;
      step_tag.end_line   = at_grp_end;
      step_tag.first_line = (row == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         lane <= '0;
         grp  <= '0;
         row  <= '0;
      end else begin
         lane <= at_lane_end ? 3'd0 : lane + 3'd1;
         if (at_lane_end) begin
            grp <= at_grp_end ? '0 : grp + XW'(1);
         end
         if (at_grp_end) begin
            row <= at_row_end ? '0 : row + YW'(1);
         end
      end
   end

endmodule

// File: rtl/lcdfmt_fetch.sv
module lcdfmt_fetch
   import lcdfmt_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int AW     = 17,
   parameter int XW     = 11,
   parameter int YW     = 10,
   localparam int LW    = $clog2(WORD_W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic [1:0]    bpp_sel,
   input  logic [XW-1:0] pitch,
   input  logic [XW-1:0] src_x,
   input  logic [YW-1:0] src_y,
   input  logic          in_vld,
   input  lane_tag_t     in_tag,
   output logic [AW-1:0] fb_addr,
   output logic          out_vld,
   output logic [LW-1:0] out_pos,
   output lane_tag_t     out_tag
);

   logic [AW-1:0] line_base;
   logic [AW-1:0] cand_word [NBPP];
   logic [LW-1:0] cand_pos  [NBPP];
   logic [1:0]    sel;

   assign line_base = AW'(src_y) * AW'(pitch);

   // one address/bit-position variant per pixel width
   for (genvar b = 0; b < NBPP; b++) begin : g_bpp
      localparam int SH = LW - b;
      logic [SH-1:0] idx;
      assign idx          = src_x[SH-1:0];
      assign cand_word[b] = AW'(src_x >> SH);
      assign cand_pos[b]  = LW'(WORD_W - 1) - (LW'(idx) << b);
   end

   always_comb begin
      sel     = (bpp_sel == BPP_4X) ? 2'd2 : bpp_sel;
      fb_addr = line_base + cand_word[sel];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         out_vld <= 1'b0;
         out_pos <= '0;
         out_tag <= '0;
      end else begin
         out_vld <= in_vld;
         out_pos <= cand_pos[sel];
         out_tag <= in_tag;
      end
   end

endmodule

// File: rtl/lcdfmt_lanes.sv
module lcdfmt_lanes
   import lcdfmt_pkg::*;
#(
   parameter int WORD_W = 16,
   localparam int LW    = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              bus8,
   input  logic [WORD_W-1:0] fb_data,
   input  logic              pix_vld,
   input  logic [LW-1:0]     pix_pos,
   input  lane_tag_t         pix_tag,
   output logic [7:0]        lcd_data,
   output logic              lcd_shclk,
   output logic              lcd_line,
   output logic              lcd_frame
);

   logic [7:0] shreg;
   logic [7:0] shnext;
   logic       line_pend;
   logic       frame_pend;

   assign shnext = {shreg[6:0], fb_data[pix_pos]};

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         shreg      <= '0;
         lcd_data   <= '0;
         lcd_shclk  <= 1'b0;
         lcd_line   <= 1'b0;
         lcd_frame  <= 1'b0;
         line_pend  <= 1'b0;
         frame_pend <= 1'b0;
      end else begin
         lcd_shclk <= 1'b0;
         lcd_line  <= line_pend;
         lcd_frame <= line_pend & frame_pend;
         line_pend <= 1'b0;
         if (pix_vld) begin
            shreg <= shnext;
            if (pix_tag.last_lane) begin
               lcd_data  <= bus8 ? shnext : {4'b0000, shnext[3:0]};
               lcd_shclk <= 1'b1;
               if (pix_tag.end_line) begin
                  line_pend  <= 1'b1;
                  frame_pend <= pix_tag.first_line;
               end
            end
         end
      end
   end

endmodule

// File: rtl/lcdfmt_top.sv
module lcdfmt_top
   import lcdfmt_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int AW     = 17,
   parameter int XW     = 11,
   parameter int YW     = 10,
   localparam int LW    = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [1:0]        bpp_sel,
   input  logic              bus8,
   input  logic              dual,
   input  logic              dot_dbl,
   input  logic              line_dbl,
   input  logic [XW-1:0]     h_active,
   input  logic [YW-1:0]     v_active,
   input  logic [XW-1:0]     pitch,
   input  logic [XW-1:0]     pan_x,
   input  logic [YW-1:0]     pan_y,
   output logic [AW-1:0]     fb_addr,
   input  logic [WORD_W-1:0] fb_data,
   output logic [7:0]        lcd_data,
   output logic              lcd_shclk,
   output logic              lcd_line,
   output logic              lcd_frame
);

   if (WORD_W < 8 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
      $error("lcdfmt_top: WORD_W must be a power of two of at least 8");
   end
   if (XW < 4 || YW < 2 || AW < 2) begin : g_bad_dims
      $error("lcdfmt_top: coordinate or address width too small");
   end

   logic [XW-1:0] src_x;
   logic [YW-1:0] src_y;
   logic          step_vld;
   lane_tag_t     step_tag;
   logic          pix_vld;
   logic [LW-1:0] pix_pos;
   lane_tag_t     pix_tag;

   lcdfmt_scan #(.XW(XW), .YW(YW)) u_scan (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .bus8(bus8), .dual(dual), .dot_dbl(dot_dbl), .line_dbl(line_dbl),
      .h_active(h_active), .v_active(v_active),
      .pan_x(pan_x), .pan_y(pan_y),
      .src_x(src_x), .src_y(src_y),
      .step_vld(step_vld), .step_tag(step_tag)
   );

   lcdfmt_fetch #(.WORD_W(WORD_W), .AW(AW), .XW(XW), .YW(YW)) u_fetch (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .bpp_sel(bpp_sel), .pitch(pitch),
      .src_x(src_x), .src_y(src_y),
      .in_vld(step_vld), .in_tag(step_tag),
      .fb_addr(fb_addr),
      .out_vld(pix_vld), .out_pos(pix_pos), .out_tag(pix_tag)
   );

   lcdfmt_lanes #(.WORD_W(WORD_W)) u_lanes (
      .clk(clk), .rst_n(rst_n), .enable(enable), .bus8(bus8),
      .fb_data(fb_data),
      .pix_vld(pix_vld), .pix_pos(pix_pos), .pix_tag(pix_tag),
      .lcd_data(lcd_data), .lcd_shclk(lcd_shclk),
      .lcd_line(lcd_line), .lcd_frame(lcd_frame)
   );

endmodule

// File: rtl/lcdfmt_chk.sv
module lcdfmt_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic       bus8,
   input logic [7:0] lcd_data,
   input logic       lcd_shclk,
   input logic       lcd_line,
   input logic       lcd_frame
);

   assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!lcd_shclk && !lcd_line && !lcd_frame));

   assert_narrow_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lcd_shclk && !bus8) |-> (lcd_data[7:4] == 4'h0));

   assert_line_follows_shclk_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_line |-> $past(lcd_shclk));

   assert_frame_with_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_frame |-> lcd_line);

   assert_shclk_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_shclk |=> !lcd_shclk);

   assert_shclk_line_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(lcd_shclk && lcd_line));

endmodule

bind lcdfmt_top lcdfmt_chk u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .bus8(bus8),
   .lcd_data(lcd_data), .lcd_shclk(lcd_shclk),
   .lcd_line(lcd_line), .lcd_frame(lcd_frame)
);

// File: tb/sim_lcdfmt_top.sv
`timescale 1ns/1ps
module sim_lcdfmt_top;

   localparam int WORD_W = 16;
   localparam int AW = 17;
   localparam int XW = 11;
   localparam int YW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic [1:0] bpp_sel = '0;
   logic bus8 = 1'b0, dual = 1'b0, dot_dbl = 1'b0, line_dbl = 1'b0;
   logic [XW-1:0] h_active = XW'(32), pitch = XW'(16), pan_x = '0;
   logic [YW-1:0] v_active = YW'(4), pan_y = '0;
   logic [AW-1:0] fb_addr;
   logic [WORD_W-1:0] fb_data = '0;
   logic [7:0] lcd_data;
   logic lcd_shclk, lcd_line, lcd_frame;

   int n_cmp = 0, n_bad = 0;
   int cyc = 0;
   bit timeout = 1'b0;
   bit mon_on = 1'b0;
   int mon_line, mon_grp, lines_seen, frames_seen, last_sh, have_sh;
   int exp_ngrp, exp_nlines, lanes;
   string dtag;

   always #10 clk = ~clk;

   lcdfmt_top #(.WORD_W(WORD_W), .AW(AW), .XW(XW), .YW(YW)) u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .bpp_sel(bpp_sel),
      .bus8(bus8), .dual(dual), .dot_dbl(dot_dbl), .line_dbl(line_dbl),
      .h_active(h_active), .v_active(v_active), .pitch(pitch),
      .pan_x(pan_x), .pan_y(pan_y), .fb_addr(fb_addr), .fb_data(fb_data),
      .lcd_data(lcd_data), .lcd_shclk(lcd_shclk),
      .lcd_line(lcd_line), .lcd_frame(lcd_frame)
   );

   function automatic logic [15:0] memf(input int a);
      int m;
      m = a & ((1 << AW) - 1);
      return 16'(m * 40503) ^ 16'(m >> 5) ^ 16'h5a3c;
   endfunction

   // R2 R5 R6 R7: panel position to lane value
   function automatic bit pix(input int x, input int r);
      int sx, sy, bpp, ppw, a;
      logic [15:0] w;
      sx = (int'(pan_x) + (dot_dbl ? x / 2 : x)) & ((1 << XW) - 1);
      sy = (int'(pan_y) + (line_dbl ? r / 2 : r)) & ((1 << YW) - 1);
      bpp = (bpp_sel == 2'd0) ? 1 : (bpp_sel == 2'd1) ? 2 : 4;
      ppw = WORD_W / bpp;
      a = sy * int'(pitch) + sx / ppw;
      w = memf(a);
      return w[15 - (sx % ppw) * bpp];
   endfunction

   // R3 R4: expected lane group
   function automatic logic [7:0] exp_group(input int y, input int g);
      logic [7:0] v;
      int lh;
      bit lower;
      v = '0;
      lh = dual ? lanes / 2 : lanes;
      for (int j = 0; j < lanes; j++) begin
         lower = dual && (j >= lh);
         v[lanes - 1 - j] = pix(g * lh + (j % lh), y + (lower ? int'(v_active) / 2 : 0));
      end
      return v;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) timeout <= 1'b1;
      fb_data <= memf(int'(fb_addr));
   end

   always @(negedge clk) begin
      if (mon_on) begin
         if (lcd_shclk) begin
            check(dtag, {24'd0, lcd_data}, {24'd0, exp_group(mon_line, mon_grp)});
            if (have_sh != 0) check("R10 shift spacing", cyc - last_sh, lanes);
            have_sh = 1;
            last_sh = cyc;
            mon_grp++;
         end
         if (lcd_line) begin
            check("R8 groups per line", mon_grp, exp_ngrp);
            check("R8 line after last shclk", cyc - last_sh, 1);
            check("R9 frame pulse", {31'd0, lcd_frame}, {31'd0, (mon_line == 0)});
            if (lcd_frame) frames_seen++;
            mon_grp = 0;
            mon_line = (mon_line + 1) % exp_nlines;
            lines_seen++;
         end
      end
   end

   task automatic run_cfg(input int bs, input bit b8, input bit du, input bit dd, input bit ld,
                          input int h, input int v, input int p, input int px, input int py);
      @(negedge clk);
      enable = 1'b0;
      bpp_sel = 2'(bs); bus8 = b8; dual = du; dot_dbl = dd; line_dbl = ld;
      h_active = XW'(h); v_active = YW'(v); pitch = XW'(p);
      pan_x = XW'(px); pan_y = YW'(py);
      lanes = b8 ? 8 : 4;
      exp_ngrp = h / (du ? lanes / 2 : lanes);
      exp_nlines = du ? v / 2 : v;
      dtag = "R2 R3";
      if (du) dtag = {dtag, " R4"};
      if (dd) dtag = {dtag, " R5"};
      if (ld) dtag = {dtag, " R6"};
      if (px != 0 || py != 0) dtag = {dtag, " R7"};
      mon_line = 0; mon_grp = 0; lines_seen = 0; frames_seen = 0; have_sh = 0; last_sh = 0;
      repeat (2) @(negedge clk);
      mon_on = 1'b1;
      enable = 1'b1;
      while (lines_seen < exp_nlines + 1 && !timeout) @(negedge clk);
      mon_on = 1'b0;
      enable = 1'b0;
      check("R9 frame pulses per run", frames_seen, 2);
      check("R4 lines per frame", lines_seen, exp_nlines + 1);
      repeat (2) @(negedge clk);
      check("R1 idle after disable", {21'd0, lcd_data, lcd_shclk, lcd_line, lcd_frame}, 32'd0);
   endtask

   initial begin
      void'($urandom(20250611));
      repeat (3) @(negedge clk);
      check("R1 reset state", {21'd0, lcd_data, lcd_shclk, lcd_line, lcd_frame}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle out of reset", {21'd0, lcd_data, lcd_shclk, lcd_line, lcd_frame}, 32'd0);
      // directed corners
      run_cfg(0, 1'b1, 1'b0, 1'b0, 1'b0, 32, 4, 8, 0, 0);
      run_cfg(1, 1'b0, 1'b0, 1'b1, 1'b0, 24, 4, 10, 0, 0);
      run_cfg(2, 1'b1, 1'b1, 1'b0, 1'b1, 32, 8, 20, 5, 3);
      run_cfg(0, 1'b0, 1'b1, 1'b1, 1'b1, 40, 6, 12, 7, 1);
      run_cfg(3, 1'b0, 1'b0, 1'b0, 1'b0, 16, 2, 6, 3, 0);
      run_cfg(1, 1'b1, 1'b1, 1'b1, 1'b0, 48, 4, 30, 13, 9);
      // random mix
      for (int k = 0; k < 14 && !timeout; k++) begin
         run_cfg($urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 8 * $urandom_range(2, 8), 2 * $urandom_range(1, 6),
                 $urandom_range(8, 40), $urandom_range(0, 63), $urandom_range(0, 31));
      end
      if (timeout) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule